// File: doc/BRIEF.md
# SPI slave error and timeout monitor

This block sits beside the shift engine of an SPI slave and watches the raw slave-select and serial clock pins, plus the empty state of the transmit FIFO. Both pins first pass through a synchroniser clocked by the system clock. Everything after that runs on synchronised edges: counting edges, tracking whether the slave is selected, and reporting what went wrong on the bus.

It raises six sticky status flags. Two mark entry into and exit from selection. One marks a partial word at deselection. One marks a transmit underrun, and one marks an underrun that is still pending at deselection. The last marks a word that took too long. While an underrun is pending, the block tells the data-out path to drive a programmed idle level. A timeout can also pulse a request to flush both FIFOs. Software clears any flag by pulsing its bit on the clear input, and a per-flag enable mask folds the flags into one interrupt line.

The block carries no data stream, so all of its pins are plain level or pulse signals with no handshake. Configuration inputs are expected to stay still while the slave is selected.

Top module: `spi_slv_mon`

## Requirements
- R1: After reset, status is all zero and miso_force_en, miso_force_val, flush_req and irq are low.
- R2: The slave is selected when the synchronised ss_in equals cfg_ss_high. Entering selection sets status[0]. Leaving selection sets status[1].
- R3: When cfg_three_wire is 1, ss_in is ignored and the slave counts as always selected. status[0] and status[1] never set, and clock edges are still counted.
- R4: On leaving selection, status[2] sets when no counting edge arrived during the selection, or when the number of counting edges is not a multiple of the effective width. The effective width is cfg_width, except that 0 or any value above MAX_BITS means MAX_BITS.
- R5: Only one serial clock edge counts as a bit: the falling edge when cfg_cnt_fall is 1, and the rising edge when it is 0.
- R6: A counting edge while selected with tx_empty high sets status[3] and starts an underrun. While the underrun lasts, miso_force_en is 1 and miso_force_val equals cfg_udr_level. The underrun ends on deselection, or at a word-ending edge with tx_empty low.
- R7: If an underrun is still pending when the slave leaves selection, status[4] sets.
- R8: The timeout counter counts system cycles while the slave is selected, cfg_to_period is non-zero, and at least one counting edge has arrived. It restarts at each word-ending edge. status[5] sets when the count reaches cfg_to_period before the current word ends. A period of 0 disables the timeout.
- R9: When cfg_auto_flush is 1, each timeout event produces exactly one single-cycle pulse on flush_req. When cfg_auto_flush is 0, flush_req stays low.
- R10: Flags are sticky. A 1 on clr[i] for one cycle clears only status[i] and leaves the other flags untouched.
- R11: irq is high exactly when some status[i] and irq_en[i] are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ss_in | input | 1 | Raw slave-select pin |
| sclk_in | input | 1 | Raw serial clock pin |
| tx_empty | input | 1 | Transmit FIFO is empty |
| cfg_ss_high | input | 1 | Slave select is active high when 1 |
| cfg_three_wire | input | 1 | Ignore slave select; always selected |
| cfg_cnt_fall | input | 1 | Count bits on falling serial clock edges |
| cfg_width | input | WIDTH_W | Word width in bits (0 means MAX_BITS) |
| cfg_to_period | input | TO_W | Timeout period in system cycles (0 disables) |
| cfg_udr_level | input | 1 | Level driven on data out during underrun |
| cfg_auto_flush | input | 1 | Request a FIFO flush on timeout |
| irq_en | input | 6 | Per-flag interrupt enable |
| clr | input | 6 | Write-1-to-clear pulses, one per flag |
| status | output | 6 | Sticky flags: [0] selected, [1] deselected, [2] bit count error, [3] underrun, [4] underrun at deselect, [5] timeout |
| miso_force_en | output | 1 | Data out must be forced (underrun pending) |
| miso_force_val | output | 1 | Level to force on data out |
| flush_req | output | 1 | One-cycle request to flush both FIFOs |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with MAX_BITS=8 (a 4-bit width field), TO_W=8 and two synchroniser stages. With these sizes it can run every width from 1 to 8 against every edge count from 0 to just over two words, under both select polarities. The timeout period is swept one value at a time across the exact threshold, which is 22 cycles for a 4-bit word with 8-cycle clock periods. An 8-bit counter also makes a long stall with period 0 reach saturation within a short run.

// File: rtl/spi_slv_mon_pkg.sv
package spi_slv_mon_pkg;
  localparam int FLAG_N       = 6;
  localparam int FL_SEL_ON    = 0;
  localparam int FL_SEL_OFF   = 1;
  localparam int FL_BIT_ERR   = 2;
  localparam int FL_UNDERRUN  = 3;
  localparam int FL_UDR_DESEL = 4;
  localparam int FL_TIMEOUT   = 5;
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q,
  output logic [N-1:0] q_prev
);
  logic [STAGES-1:0][N-1:0] pipe;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[s] <= '0;
        else        pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q_prev <= '0;
    else        q_prev <= q;
endmodule

// File: rtl/spi_slv_bitcnt.sv
module spi_slv_bitcnt #(
  parameter int WIDTH_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel,
  input  logic               inact_evt,
  input  logic               cnt_edge,
  input  logic               tx_empty,
  input  logic [WIDTH_W-1:0] eff_width,
  output logic               word_end,
  output logic               udr_hit,
  output logic               bit_err_evt,
  output logic               udr_err_evt,
  output logic               started,
  output logic               udr_active
);
  logic [WIDTH_W-1:0] bitcnt;
  logic               last_bit;

  assign last_bit    = (bitcnt == eff_width - WIDTH_W'(1));
  assign word_end    = cnt_edge & sel & last_bit;
  assign udr_hit     = cnt_edge & sel & tx_empty;
  assign bit_err_evt = inact_evt & (~started | (bitcnt != '0));
  assign udr_err_evt = inact_evt & udr_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt     <= '0;
      started    <= 1'b0;
      udr_active <= 1'b0;
    end else if (!sel) begin
      bitcnt     <= '0;
      started    <= 1'b0;
      udr_active <= 1'b0;
    end else if (cnt_edge) begin
      started <= 1'b1;
      bitcnt  <= last_bit ? '0 : bitcnt + WIDTH_W'(1);
      if (tx_empty)      udr_active <= 1'b1;
      else if (last_bit) udr_active <= 1'b0;
    end
  end

  AST_DESEL_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    inact_evt |=> (bitcnt == '0) && !started && !udr_active); // R4

  AST_CNT_BELOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && $stable(eff_width) && eff_width != '0) |-> (bitcnt < eff_width)); // R4
endmodule

// File: rtl/spi_slv_timeout.sv
module spi_slv_timeout #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel,
  input  logic            started,
  input  logic            word_end,
  input  logic [TO_W-1:0] period,
  output logic            fire
);
  logic [TO_W-1:0] cnt;
  logic            fired;
  logic            run;

  assign run  = sel & started & (period != '0);
  assign fire = run & ~fired & ~word_end & (cnt >= period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (!sel || !started || word_end) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else begin
      if (cnt != '1) cnt <= cnt + TO_W'(1);
      if (fire)      fired <= 1'b1;
    end
  end

  AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire); // R9
endmodule

// File: rtl/spi_slv_flags.sv
module spi_slv_flags #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !clr[i]) |=> flags[i]); // R10
  end
endmodule

// File: rtl/spi_slv_mon.sv
module spi_slv_mon
  import spi_slv_mon_pkg::*;
#(
  parameter  int MAX_BITS    = 32,
  parameter  int TO_W        = 16,
  parameter  int SYNC_STAGES = 2,
  localparam int WIDTH_W     = $clog2(MAX_BITS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ss_in,
  input  logic               sclk_in,
  input  logic               tx_empty,
  input  logic               cfg_ss_high,
  input  logic               cfg_three_wire,
  input  logic               cfg_cnt_fall,
  input  logic [WIDTH_W-1:0] cfg_width,
  input  logic [TO_W-1:0]    cfg_to_period,
  input  logic               cfg_udr_level,
  input  logic               cfg_auto_flush,
  input  logic [FLAG_N-1:0]  irq_en,
  input  logic [FLAG_N-1:0]  clr,
  output logic [FLAG_N-1:0]  status,
  output logic               miso_force_en,
  output logic               miso_force_val,
  output logic               flush_req,
  output logic               irq
);
  localparam int PRIME = SYNC_STAGES + 1;
  localparam int PW    = $clog2(PRIME + 1);

  logic [1:0]         pin_q, pin_p;
  logic               ss_s, sclk_s, sclk_p;
  logic [PW-1:0]      prime_cnt;
  logic               primed, sel, sel_prev;
  logic               act_evt, inact_evt, cnt_edge;
  logic [WIDTH_W-1:0] eff_width;
  logic               word_end, udr_hit, bit_err_evt, udr_err_evt;
  logic               started, udr_active, to_fire;
  logic [FLAG_N-1:0]  set_vec;

  spi_slv_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sclk_in, ss_in}), .q(pin_q), .q_prev(pin_p));

  assign ss_s   = pin_q[0];
  assign sclk_s = pin_q[1];
  assign sclk_p = pin_p[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       prime_cnt <= '0;
    else if (!primed) prime_cnt <= prime_cnt + PW'(1);

  assign primed = (prime_cnt == PW'(PRIME));
  assign sel    = primed & (cfg_three_wire | (ss_s == cfg_ss_high));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sel_prev <= 1'b0;
    else        sel_prev <= sel;

  assign act_evt   = sel & ~sel_prev & ~cfg_three_wire;
  assign inact_evt = ~sel & sel_prev & ~cfg_three_wire;
  assign cnt_edge  = primed & (cfg_cnt_fall ? (sclk_p & ~sclk_s) : (sclk_s & ~sclk_p));
  assign eff_width = (cfg_width == '0 || cfg_width > WIDTH_W'(MAX_BITS))
                     ? WIDTH_W'(MAX_BITS) : cfg_width;

  spi_slv_bitcnt #(.WIDTH_W(WIDTH_W)) u_bitcnt (
    .clk(clk), .rst_n(rst_n), .sel(sel), .inact_evt(inact_evt),
    .cnt_edge(cnt_edge), .tx_empty(tx_empty), .eff_width(eff_width),
    .word_end(word_end), .udr_hit(udr_hit), .bit_err_evt(bit_err_evt),
    .udr_err_evt(udr_err_evt), .started(started), .udr_active(udr_active));

  spi_slv_timeout #(.TO_W(TO_W)) u_timeout (
    .clk(clk), .rst_n(rst_n), .sel(sel), .started(started),
    .word_end(word_end), .period(cfg_to_period), .fire(to_fire));

  always_comb begin
    set_vec               = '0;
    set_vec[FL_SEL_ON]    = act_evt;
    set_vec[FL_SEL_OFF]   = inact_evt;
    set_vec[FL_BIT_ERR]   = bit_err_evt;
    set_vec[FL_UNDERRUN]  = udr_hit;
    set_vec[FL_UDR_DESEL] = udr_err_evt;
    set_vec[FL_TIMEOUT]   = to_fire;
  end

  spi_slv_flags #(.N(FLAG_N)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(set_vec), .clr(clr), .flags(status));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flush_req <= 1'b0;
    else        flush_req <= to_fire & cfg_auto_flush;

  assign miso_force_en  = udr_active;
  assign miso_force_val = udr_active & cfg_udr_level;
  assign irq            = |(status & irq_en);

  AST_THREE_WIRE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_three_wire |=> !$rose(status[FL_SEL_ON]) && !$rose(status[FL_SEL_OFF])); // R3

  AST_UDR_DESEL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[FL_UDR_DESEL]) |-> $past(miso_force_en)); // R7

  AST_TO_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_to_period == '0) |=> !$rose(status[FL_TIMEOUT])); // R8

  AST_FLUSH_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> status[FL_TIMEOUT]); // R9
endmodule

// File: tb/spi_slv_mon_test.sv
`timescale 1ns/1ps
module spi_slv_mon_test;
  localparam int MB = 8;
  localparam int TW = 8;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ss_in = 1'b1, sclk_in = 1'b0, tx_empty = 1'b0;
  logic cfg_ss_high = 1'b0, cfg_three_wire = 1'b0, cfg_cnt_fall = 1'b0;
  logic [3:0] cfg_width = 4'd8;
  logic [TW-1:0] cfg_to_period = '0;
  logic cfg_udr_level = 1'b0, cfg_auto_flush = 1'b0;
  logic [5:0] irq_en = '0, clr = '0;
  logic [5:0] status;
  logic miso_force_en, miso_force_val, flush_req, irq;

  int n_cmp = 0, n_bad = 0, flush_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_slv_mon #(.MAX_BITS(MB), .TO_W(TW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .ss_in(ss_in), .sclk_in(sclk_in), .tx_empty(tx_empty),
    .cfg_ss_high(cfg_ss_high), .cfg_three_wire(cfg_three_wire), .cfg_cnt_fall(cfg_cnt_fall),
    .cfg_width(cfg_width), .cfg_to_period(cfg_to_period), .cfg_udr_level(cfg_udr_level),
    .cfg_auto_flush(cfg_auto_flush), .irq_en(irq_en), .clr(clr), .status(status),
    .miso_force_en(miso_force_en), .miso_force_val(miso_force_val),
    .flush_req(flush_req), .irq(irq));

  always @(posedge clk) if (rst_n && flush_req) flush_cnt <= flush_cnt + 1;

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    @(negedge clk);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
    @(posedge clk);
    #1;
  endtask

  task automatic ss_set(bit on);
    ss_in = on ? cfg_ss_high : ~cfg_ss_high;
  endtask

  task automatic pulses(int n);
    for (int k = 0; k < n; k++) begin
      sclk_in = 1'b1; cyc(HALF);
      sclk_in = 1'b0; cyc(HALF);
    end
  endtask

  task automatic clear_all();
    clr = 6'h3F; cyc(1);
    clr = 6'h00; cyc(1);
  endtask

  task automatic session(int n);
    ss_set(1); cyc(6);
    pulses(n); cyc(6);
    ss_set(0); cyc(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(5);
    rst_n = 1'b1;
    cyc(8);
    // R1 reset state
    chk("R1", "status", 32'(status), 32'h0);
    chk("R1", "force_en", 32'(miso_force_en), 32'h0);
    chk("R1", "force_val", 32'(miso_force_val), 32'h0);
    chk("R1", "flush_req", 32'(flush_req), 32'h0);
    chk("R1", "irq", 32'(irq), 32'h0);

    // R2 / R4 sweep over polarity, width and edge count
    for (int pol = 0; pol < 2; pol++) begin
      cfg_ss_high = pol[0]; ss_set(0); cyc(6); clear_all();
      ss_set(1); cyc(6);
      chk("R2", "select flags while selected", 32'(status[1:0]), 32'h1);
      ss_set(0); cyc(6);
      chk("R2", "select flags after deselect", 32'(status[1:0]), 32'h3);
      for (int w = 1; w <= MB; w++) begin
        cfg_width = 4'(w);
        for (int n = 0; n <= 2 * w + 1; n++) begin
          clear_all();
          session(n);
          chk("R4", $sformatf("bit error pol=%0d w=%0d n=%0d", pol, w, n),
              32'(status[2]), 32'((n == 0) || (n % w != 0)));
          chk("R2", "both select flags", 32'(status[1:0]), 32'h3);
        end
      end
    end
    // R4 width 0 and width above max mean MAX_BITS
    cfg_width = 4'd0; clear_all(); session(MB);
    chk("R4", "width 0 full word", 32'(status[2]), 32'h0);
    clear_all(); session(MB - 1);
    chk("R4", "width 0 partial", 32'(status[2]), 32'h1);
    cfg_width = 4'd12; clear_all(); session(MB);
    chk("R4", "width 12 clamps", 32'(status[2]), 32'h0);

    // R5 counting edge selection: rise only, then deselect before fall
    cfg_width = 4'd1;
    for (int f = 0; f < 2; f++) begin
      cfg_cnt_fall = f[0]; clear_all();
      ss_set(1); cyc(6); sclk_in = 1'b1; cyc(6); ss_set(0); cyc(6);
      sclk_in = 1'b0; cyc(6);
      chk("R5", $sformatf("rise-only count fall=%0d", f), 32'(status[2]), 32'(f));
    end

    // R6 / R7 underrun
    cfg_width = 4'd3;
    for (int lv = 0; lv < 2; lv++) begin
      for (int f = 0; f < 2; f++) begin
        cfg_udr_level = lv[0]; cfg_cnt_fall = f[0]; tx_empty = 1'b1; clear_all();
        ss_set(1); cyc(6); pulses(1); cyc(4);
        chk("R6", "underrun flag", 32'(status[3]), 32'h1);
        chk("R6", "force_en", 32'(miso_force_en), 32'h1);
        chk("R6", "force_val", 32'(miso_force_val), 32'(lv));
        pulses(2); cyc(2); ss_set(0); cyc(6);
        chk("R7", "underrun at deselect", 32'(status[4]), 32'h1);
        chk("R6", "force released", 32'(miso_force_en), 32'h0);
      end
    end
    cfg_cnt_fall = 1'b0;
    tx_empty = 1'b0; clear_all(); session(3);
    chk("R6", "no underrun when fed", 32'(status[4:3]), 32'h0);
    tx_empty = 1'b1; clear_all();
    ss_set(1); cyc(6); pulses(1); tx_empty = 1'b0; pulses(2); cyc(4);
    chk("R6", "refill ends underrun at word end", 32'(miso_force_en), 32'h0);
    ss_set(0); cyc(6);
    chk("R7", "no deselect error after refill", 32'(status[4:3]), 32'h1 << 0 | 32'h0 + 32'h1);

    // R3 three-wire mode
    cfg_three_wire = 1'b1; tx_empty = 1'b1; cyc(6); clear_all();
    ss_in = 1'b0; cyc(8); ss_in = 1'b1; cyc(8); ss_in = ~cfg_ss_high; cyc(8);
    chk("R3", "no select events", 32'(status[1:0]), 32'h0);
    pulses(1); cyc(4);
    chk("R3", "edges counted though ss inactive", 32'(status[3]), 32'h1);
    chk("R3", "force while ss inactive", 32'(miso_force_en), 32'h1);
    cfg_three_wire = 1'b0; tx_empty = 1'b0; cyc(6); clear_all();

    // R10 / R11 selective clear and interrupt mask
    cfg_width = 4'd3; session(2);
    chk("R10", "flags set", 32'(status), 32'h7);
    clr = 6'b000100; cyc(1); clr = '0; cyc(2);
    chk("R10", "only bit 2 cleared", 32'(status), 32'h3);
    irq_en = 6'b000100; cyc(1);
    chk("R11", "masked irq", 32'(irq), 32'h0);
    irq_en = 6'b000010; cyc(1);
    chk("R11", "enabled irq", 32'(irq), 32'h1);
    clr = 6'b000010; cyc(1); clr = '0; cyc(2);
    chk("R11", "irq drops after clear", 32'(irq), 32'h0);
    chk("R10", "bit 0 kept", 32'(status), 32'h1);
    irq_en = '0;

    // R8 / R9 timeout threshold sweep: width 4, 8-cycle clock, limit 22
    cfg_width = 4'd4; cfg_auto_flush = 1'b1;
    for (int p = 18; p <= 26; p++) begin
      int fc0;
      cfg_to_period = TW'(p); clear_all(); fc0 = flush_cnt;
      session(4);
      chk("R8", $sformatf("timeout period=%0d", p), 32'(status[5]), 32'(p <= 22));
      chk("R9", $sformatf("flush pulses period=%0d", p), 32'(flush_cnt - fc0), 32'(p <= 22));
    end
    begin
      int fc0;
      cfg_to_period = TW'(40); clear_all(); fc0 = flush_cnt;
      session(12);
      chk("R8", "multi-word within period", 32'(status[5]), 32'h0);
      cfg_to_period = '0; clear_all();
      ss_set(1); cyc(6); pulses(2); cyc(300); ss_set(0); cyc(6);
      chk("R8", "period 0 disables", 32'(status[5]), 32'h0);
      cfg_to_period = TW'(40); clear_all(); fc0 = flush_cnt;
      ss_set(1); cyc(6); pulses(2); cyc(200); ss_set(0); cyc(6);
      chk("R8", "stall times out", 32'(status[5]), 32'h1);
      chk("R9", "single flush pulse", 32'(flush_cnt - fc0), 32'h1);
      cfg_auto_flush = 1'b0; clear_all(); fc0 = flush_cnt;
      ss_set(1); cyc(6); pulses(2); cyc(100); ss_set(0); cyc(6);
      chk("R8", "stall times out no flush", 32'(status[5]), 32'h1);
      chk("R9", "no flush when disabled", 32'(flush_cnt - fc0), 32'h0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule